// File: doc/BRIEF.md
# NOR Flash Word Program Sequencer

This block masters a parallel NOR flash bus to program a single bus word. A request names an operation, a target address, a data word and a fast flag. For a program, the block writes the command prefix cycles and then the data word. It waits a fixed settle time and asks an external status poller to watch the device. When the poller answers, the block reports either completion or failure.

Two further operations switch the device in and out of a bypass mode. While that mode is active, a fast program needs only one prefix cycle ahead of the data word, so a burst of words costs less bus time. If a program fails while bypass is active, the block first takes the device out of bypass and only then reports the error.

Each bus write has three parts: a setup phase in which address and data are driven, a write strobe held low for a set number of clocks, and a hold phase. A low bus-ready input stalls a cycle before its strobe falls. All command cycles are byte-wide codes on the low eight data lines, whatever the bus width.

Top module: `nor_prog_seq`

## Requirements
- R1: A program request (op 2'b00) with fast low writes 0xAA to unlock address 1, then 0x55 to unlock address 2, then 0xA0 to unlock address 1, and then the data word to the target address. After the poller passes, done pulses for one clock.
- R2: A program request with fast high, made while bypass is active, writes exactly two cycles: 0xA0 to address 0, then the data word to the target address.
- R3: In every bus write, bus_we_n stays low for exactly PULSE_CYC clocks, and bus_addr and bus_dout do not change while it is low.
- R4: In every command cycle, the data bits above bit 7 are zero. The code sits on bus_dout[7:0].
- R5: poll_start pulses no sooner than WAIT_CYC clocks after bus_we_n rises at the end of the data write.
- R6: An enter request (op 2'b01) writes 0xAA to unlock address 1, 0x55 to unlock address 2, then 0x20 to unlock address 1. It then sets bypass_active and pulses done.
- R7: A leave request (op 2'b10) writes 0x90 to address 0, then 0x00 to address 0. It then clears bypass_active and pulses done.
- R8: If the poller reports failure while bypass is active, the block writes the two leave cycles of R7, clears bypass_active and pulses error, not done. If it fails with bypass inactive, error pulses with no further writes.
- R9: A program request with fast high, made while bypass is inactive, runs the four-cycle sequence of R1.
- R10: busy is high from acceptance until the operation ends. A request made while busy has no effect. Op 2'b11 has no effect.
- R11: After reset, bus_we_n is high, and busy, bypass_active, done, error and poll_start are low.
- R12: While bus_ready is low, no write strobe falls. The cycle proceeds once bus_ready goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| unlock_addr1 | input | ADDR_W | First unlock address |
| unlock_addr2 | input | ADDR_W | Second unlock address |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_op | input | 2 | 00 program, 01 enter bypass, 10 leave bypass, 11 none |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Word to program |
| req_fast | input | 1 | Use the bypass program form if bypass is active |
| busy | output | 1 | Operation in progress |
| bypass_active | output | 1 | Device is in bypass mode |
| bus_addr | output | ADDR_W | Flash bus address |
| bus_dout | output | DATA_W | Flash bus write data |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_ready | input | 1 | Bus may start a strobe |
| poll_start | output | 1 | Pulse: start status polling |
| poll_done | input | 1 | Poller result valid |
| poll_fail | input | 1 | Poller result is failure |
| done | output | 1 | Pulse: operation succeeded |
| error | output | 1 | Pulse: program failed |

## Verification
Four properties are checked on every clock. Address and data must hold still while the strobe is low. A strobe may only fall during an accepted operation. Done and error must never pulse together. Bypass may only change state at the end of an enter or leave sequence.

The other behaviours are visible only through bench scenarios. These are the exact order, addresses and codes of each sequence, and the choice between the short and long program forms. They also cover the automatic exit from bypass after a failure, the settle time before polling, and the stall under a low bus_ready.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

    typedef enum logic [1:0] {
        SEQ_PROG_STD  = 2'd0,
        SEQ_PROG_BYP  = 2'd1,
        SEQ_BYP_ENTER = 2'd2,
        SEQ_BYP_LEAVE = 2'd3
    } seq_e;

    typedef enum logic [1:0] {
        AS_UNLOCK1 = 2'd0,
        AS_UNLOCK2 = 2'd1,
        AS_BASE    = 2'd2,
        AS_TARGET  = 2'd3
    } asel_e;

    typedef struct packed {
        asel_e      asel;
        logic       use_data;
        logic [7:0] code;
        logic       last;
    } step_t;

    localparam logic [1:0] OP_PROG  = 2'b00;
    localparam logic [1:0] OP_ENTER = 2'b01;
    localparam logic [1:0] OP_LEAVE = 2'b10;
    localparam logic [1:0] OP_NONE  = 2'b11;

    // Bus cycle list of each sequence, indexed by step number
    function automatic step_t step_of(seq_e seq, logic [1:0] idx);
        step_t s;
        s = '{asel: AS_BASE, use_data: 1'b0, code: 8'h00, last: 1'b1};
        case (seq)
            SEQ_PROG_STD: case (idx)
                2'd0:    s = '{AS_UNLOCK1, 1'b0, 8'hAA, 1'b0};
                2'd1:    s = '{AS_UNLOCK2, 1'b0, 8'h55, 1'b0};
                2'd2:    s = '{AS_UNLOCK1, 1'b0, 8'hA0, 1'b0};
                default: s = '{AS_TARGET,  1'b1, 8'h00, 1'b1};
            endcase
            SEQ_PROG_BYP: case (idx)
                2'd0:    s = '{AS_BASE,    1'b0, 8'hA0, 1'b0};
                default: s = '{AS_TARGET,  1'b1, 8'h00, 1'b1};
            endcase
            SEQ_BYP_ENTER: case (idx)
                2'd0:    s = '{AS_UNLOCK1, 1'b0, 8'hAA, 1'b0};
                2'd1:    s = '{AS_UNLOCK2, 1'b0, 8'h55, 1'b0};
                default: s = '{AS_UNLOCK1, 1'b0, 8'h20, 1'b1};
            endcase
            default: case (idx)
                2'd0:    s = '{AS_BASE,    1'b0, 8'h90, 1'b0};
                default: s = '{AS_BASE,    1'b0, 8'h00, 1'b1};
            endcase
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_we_n,
    output logic              cyc_done
);
    localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                          ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
    localparam int CW = $clog2(MAXC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} ph_e;

    typedef struct packed {
        ph_e               ph;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              we_n;
    } cyc_st_t;

    cyc_st_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.ph)
            PH_IDLE: if (start) begin
                r_d.ph   = PH_SETUP;
                r_d.cnt  = CW'(SETUP_CYC - 1);
                r_d.addr = addr_in;
                r_d.data = data_in;
            end
            PH_SETUP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (bus_ready) begin
                    r_d.ph  = PH_LOW;
                    r_d.cnt = CW'(PULSE_CYC - 1);
                end
            end
            PH_LOW: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.ph  = PH_HOLD;
                    r_d.cnt = CW'(HOLD_CYC - 1);
                end
            end
            default: begin
                if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;
                else               r_d.ph  = PH_IDLE;
            end
        endcase
        r_d.we_n = (r_d.ph != PH_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, cnt: '0, addr: '0, data: '0, we_n: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_addr = r_q.addr;
    assign bus_dout = r_q.data;
    assign bus_we_n = r_q.we_n;
    assign cyc_done = (r_q.ph == PH_HOLD) && (r_q.cnt == '0);

    // R3: address and data frozen while the strobe is low
    assert_strobe_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.we_n && $past(!r_q.we_n)) |-> ($stable(r_q.addr) && $stable(r_q.data)));

endmodule

// File: rtl/nor_prog_ctrl.sv
module nor_prog_ctrl
    import nor_prog_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int WAIT_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] unlock_addr1,
    input  logic [ADDR_W-1:0] unlock_addr2,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_fast,
    input  logic              cyc_done,
    input  logic              poll_done,
    input  logic              poll_fail,
    output logic              cyc_start,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data,
    output logic              busy,
    output logic              bypass_active,
    output logic              poll_start,
    output logic              done,
    output logic              error
);
    localparam int WW = $clog2(WAIT_CYC + 1);

    typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT, C_POLL} cst_e;

    typedef struct packed {
        cst_e              st;
        seq_e              seq;
        logic [1:0]        idx;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [WW-1:0]     cnt;
        logic              byp;
        logic              fail_pend;
        logic              start;
        logic              poll;
        logic              done;
        logic              err;
    } ctl_st_t;

    ctl_st_t r_q, r_d;
    step_t   step;

    assign step = step_of(r_q.seq, r_q.idx);

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.poll  = 1'b0;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        case (r_q.st)
            C_IDLE: if (req_valid && req_op != OP_NONE) begin
                r_d.st        = C_ISSUE;
                r_d.idx       = 2'd0;
                r_d.start     = 1'b1;
                r_d.addr      = req_addr;
                r_d.data      = req_data;
                r_d.fail_pend = 1'b0;
                case (req_op)
                    OP_PROG:  r_d.seq = (req_fast && r_q.byp) ? SEQ_PROG_BYP : SEQ_PROG_STD;
                    OP_ENTER: r_d.seq = SEQ_BYP_ENTER;
                    default:  r_d.seq = SEQ_BYP_LEAVE;
                endcase
            end
            C_ISSUE: if (cyc_done) begin
                if (!step.last) begin
                    r_d.idx   = r_q.idx + 2'd1;
                    r_d.start = 1'b1;
                end else begin
                    case (r_q.seq)
                        SEQ_BYP_ENTER: begin
                            r_d.byp  = 1'b1;
                            r_d.done = 1'b1;
                            r_d.st   = C_IDLE;
                        end
                        SEQ_BYP_LEAVE: begin
                            r_d.byp  = 1'b0;
                            r_d.done = !r_q.fail_pend;
                            r_d.err  = r_q.fail_pend;
                            r_d.st   = C_IDLE;
                        end
                        default: begin
                            r_d.st  = C_WAIT;
                            r_d.cnt = WW'(WAIT_CYC - 1);
                        end
                    endcase
                end
            end
            C_WAIT: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.st   = C_POLL;
                    r_d.poll = 1'b1;
                end
            end
            default: if (poll_done) begin
                if (!poll_fail) begin
                    r_d.done = 1'b1;
                    r_d.st   = C_IDLE;
                end else if (r_q.byp) begin
                    r_d.seq       = SEQ_BYP_LEAVE;
                    r_d.idx       = 2'd0;
                    r_d.start     = 1'b1;
                    r_d.fail_pend = 1'b1;
                    r_d.st        = C_ISSUE;
                end else begin
                    r_d.err = 1'b1;
                    r_d.st  = C_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: C_IDLE, seq: SEQ_PROG_STD, idx: '0, addr: '0, data: '0,
                     cnt: '0, byp: 1'b0, fail_pend: 1'b0, start: 1'b0,
                     poll: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (step.asel)
            AS_UNLOCK1: cyc_addr = unlock_addr1;
            AS_UNLOCK2: cyc_addr = unlock_addr2;
            AS_TARGET:  cyc_addr = r_q.addr;
            default:    cyc_addr = '0;
        endcase
        cyc_data = step.use_data ? r_q.data : DATA_W'(step.code);
    end

    assign cyc_start     = r_q.start;
    assign busy          = (r_q.st != C_IDLE);
    assign bypass_active = r_q.byp;
    assign poll_start    = r_q.poll;
    assign done          = r_q.done;
    assign error         = r_q.err;

    // R8: an operation ends in exactly one way
    assert_done_error_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.done && r_q.err));

    // R6: bypass only turns on at the end of an enter sequence
    assert_bypass_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.byp) |-> ($past(r_q.seq) == SEQ_BYP_ENTER && $past(cyc_done)));

    // R7: bypass only turns off at the end of a leave sequence
    assert_bypass_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.byp) |-> ($past(r_q.seq) == SEQ_BYP_LEAVE && $past(cyc_done)));

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1,
    parameter int WAIT_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] unlock_addr1,
    input  logic [ADDR_W-1:0] unlock_addr2,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_fast,
    output logic              busy,
    output logic              bypass_active,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_we_n,
    input  logic              bus_ready,
    output logic              poll_start,
    input  logic              poll_done,
    input  logic              poll_fail,
    output logic              done,
    output logic              error
);
    logic              cyc_start;
    logic              cyc_done;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_data;

    nor_prog_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .unlock_addr1(unlock_addr1), .unlock_addr2(unlock_addr2),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_fast(req_fast),
        .cyc_done(cyc_done), .poll_done(poll_done), .poll_fail(poll_fail),
        .cyc_start(cyc_start), .cyc_addr(cyc_addr), .cyc_data(cyc_data),
        .busy(busy), .bypass_active(bypass_active), .poll_start(poll_start),
        .done(done), .error(error)
    );

    nor_bus_cycle #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_cycle (
        .clk(clk), .rst_n(rst_n),
        .start(cyc_start), .addr_in(cyc_addr), .data_in(cyc_data),
        .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_we_n(bus_we_n),
        .cyc_done(cyc_done)
    );

    // R10: no strobe outside an accepted operation
    assert_strobe_in_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> busy);

endmodule

// File: tb/nor_prog_seq_tb.sv
module nor_prog_seq_tb;
    localparam int PULSE = 3;
    localparam int WAITC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b11;
    logic [15:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        req_fast = 1'b0;
    logic        bus_ready = 1'b1;
    logic        poll_done = 1'b0;
    logic        poll_fail = 1'b0;
    logic        busy, bypass_active, bus_we_n, poll_start, done, error;
    logic [15:0] bus_addr, bus_dout;

    always #5 clk = ~clk;

    nor_prog_seq #(.PULSE_CYC(PULSE), .WAIT_CYC(WAITC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .unlock_addr1(16'h0555), .unlock_addr2(16'h02AA),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_fast(req_fast),
        .busy(busy), .bypass_active(bypass_active),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_we_n(bus_we_n),
        .bus_ready(bus_ready), .poll_start(poll_start),
        .poll_done(poll_done), .poll_fail(poll_fail),
        .done(done), .error(error)
    );

    int total = 0, fails = 0, cycles = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Bus monitor: logs each write at strobe rise
    logic [15:0] log_a [16];
    logic [15:0] log_d [16];
    int          log_w [16];
    int          log_n = 0, lowcnt = 0, since = 0, poll_gap = -1, unstable = 0, low_seen = 0;
    logic        prev_low = 1'b0;
    logic [15:0] h_a = '0, h_d = '0;

    always @(negedge clk) begin
        cycles++;
        if (!bus_we_n) begin
            low_seen++;
            if (prev_low && (bus_addr != h_a || bus_dout != h_d)) unstable++;
            h_a = bus_addr;
            h_d = bus_dout;
            lowcnt = prev_low ? lowcnt + 1 : 1;
        end else if (prev_low) begin
            if (log_n < 16) begin
                log_a[log_n] = h_a; log_d[log_n] = h_d; log_w[log_n] = lowcnt;
            end
            log_n++;
            since = 0;
        end else begin
            since++;
        end
        prev_low = !bus_we_n;
        if (poll_start) poll_gap = since;
    end

    // Status poller model
    logic resp_fail = 1'b0;
    int   pend = 0;
    always @(negedge clk) begin
        poll_done <= 1'b0;
        if (poll_start) pend <= 3;
        else if (pend != 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                poll_done <= 1'b1;
                poll_fail <= resp_fail;
            end
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cycles > 150000) begin
            fails++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Expected-sequence model
    logic [15:0] exp_a [8];
    logic [15:0] exp_d [8];
    bit          exp_cmd [8];
    int          exp_n;
    bit          byp_m = 1'b0;

    task automatic push(input logic [15:0] a, input logic [15:0] d, input bit c);
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_cmd[exp_n] = c; exp_n++;
    endtask

    task automatic build_exp(input logic [1:0] op, input logic fast,
                             input logic [15:0] a, input logic [15:0] d, input logic fail);
        exp_n = 0;
        case (op)
            2'b00: begin
                if (fast && byp_m) begin
                    push(16'h0000, 16'h00A0, 1); push(a, d, 0);
                end else begin
                    push(16'h0555, 16'h00AA, 1); push(16'h02AA, 16'h0055, 1);
                    push(16'h0555, 16'h00A0, 1); push(a, d, 0);
                end
                if (fail && byp_m) begin
                    push(16'h0000, 16'h0090, 1); push(16'h0000, 16'h0000, 1);
                    byp_m = 1'b0;
                end
            end
            2'b01: begin
                push(16'h0555, 16'h00AA, 1); push(16'h02AA, 16'h0055, 1);
                push(16'h0555, 16'h0020, 1); byp_m = 1'b1;
            end
            2'b10: begin
                push(16'h0000, 16'h0090, 1); push(16'h0000, 16'h0000, 1); byp_m = 1'b0;
            end
            default: ;
        endcase
    endtask

    bit saw_done, saw_err;

    task automatic start_op(input logic [1:0] op, input logic fast,
                            input logic [15:0] a, input logic [15:0] d, input logic fail);
        log_n = 0; poll_gap = -1; saw_done = 0; saw_err = 0; resp_fail = fail;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_fast = fast; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) saw_done = 1;
            if (error) saw_err = 1;
            if (saw_done || saw_err) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_log(input string tag);
        chk(log_n == exp_n, tag, "write count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_a[i] == exp_a[i], tag, "write address", log_a[i], exp_a[i]);
            chk(log_d[i] == exp_d[i], tag, "write data", log_d[i], exp_d[i]);
            chk(log_w[i] == PULSE, "R3", "strobe width", log_w[i], PULSE);
            if (exp_cmd[i]) chk(log_d[i][15:8] == 8'h00, "R4", "command upper byte", log_d[i][15:8], 0);
        end
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic        fast;
        logic        fail;
        logic [15:0] a;
        logic [15:0] d;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 1'b0, 16'h1234, 16'hBEEF},
        '{2'b00, 1'b1, 1'b0, 16'h0020, 16'hC3C3},
        '{2'b01, 1'b0, 1'b0, 16'h0000, 16'h0000},
        '{2'b00, 1'b1, 1'b0, 16'h0040, 16'hA5A5},
        '{2'b00, 1'b1, 1'b1, 16'h0042, 16'h5A5A},
        '{2'b01, 1'b0, 1'b0, 16'h0000, 16'h0000},
        '{2'b10, 1'b0, 1'b0, 16'h0000, 16'h0000},
        '{2'b00, 1'b0, 1'b1, 16'h7FFE, 16'hFFFF}
    };

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_we_n == 1'b1, "R11", "we_n in reset", bus_we_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, bypass_active, done, error, poll_start} == 5'b0, "R11", "flags after reset",
            {busy, bypass_active, done, error, poll_start}, 0);
        chk(bus_we_n == 1'b1, "R11", "we_n after reset", bus_we_n, 1);

        foreach (VECS[k]) begin
            string tag;
            bit    exp_err;
            vec_t  v;
            v = VECS[k];
            if (v.op == 2'b01)                     tag = "R6";
            else if (v.op == 2'b10)                tag = "R7";
            else if (v.fail)                       tag = "R8";
            else if (v.fast && !byp_m)             tag = "R9";
            else if (v.fast)                       tag = "R2";
            else                                   tag = "R1";
            exp_err = (v.op == 2'b00) && v.fail;
            build_exp(v.op, v.fast, v.a, v.d, v.fail);
            start_op(v.op, v.fast, v.a, v.d, v.fail);
            wait_end();
            compare_log(tag);
            chk(saw_done == !exp_err, tag, "done pulse", saw_done, !exp_err);
            chk(saw_err == exp_err, tag, "error pulse", saw_err, exp_err);
            chk(bypass_active == byp_m, tag, "bypass state", bypass_active, byp_m);
            chk(busy == 1'b0, tag, "busy at end", busy, 0);
            if (v.op == 2'b00)
                chk(poll_gap >= WAITC, "R5", "poll delay", poll_gap, WAITC);
        end

        // R10: request while busy is ignored
        build_exp(2'b00, 1'b0, 16'h0100, 16'h1111, 1'b0);
        start_op(2'b00, 1'b0, 16'h0100, 16'h1111, 1'b0);
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R10", "busy during op", busy, 1);
        req_valid = 1'b1; req_op = 2'b01;
        @(negedge clk);
        req_valid = 1'b0;
        wait_end();
        repeat (40) @(negedge clk);
        compare_log("R10");
        chk(bypass_active == 1'b0, "R10", "bypass after busy request", bypass_active, 0);
        chk(busy == 1'b0, "R10", "idle after op", busy, 0);

        // R10: op 11 does nothing
        start_op(2'b11, 1'b0, 16'h0200, 16'h2222, 1'b0);
        chk(busy == 1'b0, "R10", "busy after op 11", busy, 0);
        wait_end();
        chk(log_n == 0, "R10", "writes after op 11", log_n, 0);
        chk(saw_done == 0 && saw_err == 0, "R10", "ending after op 11", saw_done, 0);

        // R12: bus_ready low stalls the strobe
        bus_ready = 1'b0;
        low_seen = 0;
        build_exp(2'b00, 1'b0, 16'h0300, 16'h3333, 1'b0);
        start_op(2'b00, 1'b0, 16'h0300, 16'h3333, 1'b0);
        repeat (30) @(negedge clk);
        chk(low_seen == 0, "R12", "strobe lows while not ready", low_seen, 0);
        chk(busy == 1'b1, "R12", "busy while stalled", busy, 1);
        bus_ready = 1'b1;
        wait_end();
        compare_log("R12");
        chk(saw_done == 1, "R12", "done after stall", saw_done, 1);

        chk(unstable == 0, "R3", "bus changes during strobe", unstable, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule